// File: doc/BRIEF.md
# Leaf Page Permission Checker with Shadow-Stack Pages

This block takes a single leaf page-table entry and the attributes of one memory access, and decides whether that access may proceed. If it may not, the block reports which fault to raise. It also supports a shadow-stack page type. When shadow stacks are enabled, the encoding "writable, not readable, not executable" marks such a page. Two mismatches raise access faults instead of page faults: an ordinary access that touches a shadow-stack page, and a shadow-stack access that touches an ordinary page.

Alongside the verdict, the block returns the access kind that the physical-protection stage downstream should apply. A shadow-stack access is always passed on as a store. Requests enter through a valid/ready handshake. Each accepted request produces one registered response one cycle later, and the response is held until the consumer takes it. The caller walks the page table and supplies two flags with each request: bare (no translation) and superpage misalignment.

Top module: `leaf_perm_check`

## Requirements
- R1: After reset, `rsp_valid` is low and `req_ready` is high.
- R2: A request is accepted on a clock edge where `req_valid` and `req_ready` are both high, and its response is valid after that edge. `req_ready` equals `!rsp_valid || rsp_ready`. While `rsp_valid` is high and `rsp_ready` is low, the response fields stay unchanged. Responses leave in the order their requests were accepted. The verdict codes are 00 ok, 01 page fault, 10 store access fault and 11 instruction access fault.
- R3: The access kind codes are 00 load, 01 store and 10 fetch, and code 11 behaves as a load. `rsp_eff_kind` is 01 for any shadow-stack access. Otherwise it is the requested kind, with code 11 reported as 00. All later checks use this effective kind.
- R4: With `bare` high, a shadow-stack access gets 10. Any other access gets 00, whatever the entry bits and the misalignment flag.
- R5: The user-bit check fails in three cases: a user page (`pte_u`=1) with a supervisor fetch, a user page with any supervisor access while `sum` is 0, and a non-user page accessed in user mode. The result is 01.
- R6: The result is 01 in three cases: `pte_v` is 0; the entry has X=1, W=1, R=0; or the entry has X=0, W=1, R=0 while `ss_en` is 0.
- R7: When `ss_en` is 1, an ordinary store (not a shadow-stack access) to a page with X=0, W=1, R=0 gets 10.
- R8: When `ss_en` is 1, a fetch from a page with X=0, W=1, R=0 gets 11.
- R9: A shadow-stack access to a page that has X=1, or has both R and W set, gets 10.
- R10: Ordinary rules apply to the effective kind. A fetch needs X. A load needs R, or X when `mxr` is 1. A store needs W. Failing the rule gives 01. A shadow-stack access to a page with X=0, W=1, R=0 passes when `ss_en` is 1.
- R11: An access that passes every earlier check but has `sp_misal` high gets 01.
- R12: The checks are applied in this order, and only the first failure is reported: bare shadow-stack, user bit, invalid encodings, store access mismatch, fetch mismatch, shadow-stack mismatch, ordinary rules, misalignment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| pte_v | input | 1 | Entry valid bit |
| pte_r | input | 1 | Entry read permission |
| pte_w | input | 1 | Entry write permission |
| pte_x | input | 1 | Entry execute permission |
| pte_u | input | 1 | Entry user-accessible bit |
| acc_kind | input | 2 | Access kind (00 load, 01 store, 10 fetch, 11 load) |
| ss_acc | input | 1 | Access is a shadow-stack access |
| ss_en | input | 1 | Shadow-stack pages enabled |
| priv_super | input | 1 | Access made in supervisor mode (0 = user) |
| sum | input | 1 | Supervisor may touch user pages |
| mxr | input | 1 | Executable pages are readable |
| bare | input | 1 | Translation is off |
| sp_misal | input | 1 | Superpage frame number misaligned |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_verdict | output | 2 | Fault verdict code |
| rsp_eff_kind | output | 2 | Access kind for the protection stage |

## Verification
The assertions assume that all request fields are meaningful only in a cycle where a request is accepted. They also assume that the caller derives `bare` and `sp_misal` consistently, so that a bare request carries no entry worth checking. The stimulus therefore changes every field freely between accepted requests. It does not model the page walker. Instead it sweeps all combinations of entry bits, kinds and mode flags, including the unused kind code 11, while `rsp_ready` is withdrawn at random so that held responses and back-pressure on `req_ready` are exercised.

// File: rtl/lpc_pkg.sv
package lpc_pkg;
  localparam int KIND_W = 2;
  localparam int VERD_W = 2;

  typedef enum logic [KIND_W-1:0] {
    K_LOAD  = 2'd0,
    K_STORE = 2'd1,
    K_FETCH = 2'd2,
    K_ALT   = 2'd3
  } kind_e;

  typedef enum logic [VERD_W-1:0] {
    VD_OK  = 2'd0,
    VD_PF  = 2'd1,
    VD_SAF = 2'd2,
    VD_IAF = 2'd3
  } verdict_e;

  typedef struct packed {
    logic v;
    logic r;
    logic w;
    logic x;
    logic u;
  } pte_t;

  // kind seen by all checks: shadow-stack access becomes a store, code 3 a load
  function automatic kind_e eff_kind(input logic [KIND_W-1:0] k, input logic ss);
    if (ss) return K_STORE;
    case (k)
      2'd1:    return K_STORE;
      2'd2:    return K_FETCH;
      default: return K_LOAD;
    endcase
  endfunction

  // write-only encoding: candidate shadow-stack page
  function automatic logic wo_page(input pte_t p);
    return !p.r && p.w && !p.x;
  endfunction

  function automatic logic user_blocked(input pte_t p, input kind_e k,
                                        input logic sup, input logic sum_i);
    if (p.u) return sup && ((k == K_FETCH) || !sum_i);
    return !sup;
  endfunction

  function automatic logic plain_denied(input pte_t p, input kind_e k, input logic mxr_i);
    case (k)
      K_FETCH: return !p.x;
      K_STORE: return !p.w;
      default: return !p.r && !(mxr_i && p.x);
    endcase
  endfunction
endpackage

// File: rtl/lpc_rules.sv
module lpc_rules
  import lpc_pkg::*;
(
  input  pte_t              pte,
  input  logic [KIND_W-1:0] kind_in,
  input  logic              ss_acc,
  input  logic              ss_en,
  input  logic              priv_super,
  input  logic              sum,
  input  logic              mxr,
  input  logic              bare,
  input  logic              sp_misal,
  output logic [VERD_W-1:0] verdict,
  output logic [KIND_W-1:0] eff_out,
  output logic              u_fail,
  output logic              enc_bad,
  output logic              ss_mismatch,
  output logic              perm_bad
);
  kind_e k;
  logic  is_wo;
  logic  st_on_ss, fe_on_ss;

  always_comb begin
    k           = eff_kind(kind_in, ss_acc);
    is_wo       = wo_page(pte);
    u_fail      = user_blocked(pte, k, priv_super, sum);
    enc_bad     = !pte.v || (!pte.r && pte.w && (pte.x || !ss_en));
    st_on_ss    = is_wo && (k == K_STORE) && !ss_acc;
    fe_on_ss    = is_wo && (k == K_FETCH);
    ss_mismatch = ss_acc && ((pte.r && pte.w) || pte.x);
    perm_bad    = plain_denied(pte, k, mxr);
  end

  // priority chain: first failing check wins
  always_comb begin
    if (bare)              verdict = ss_acc ? VD_SAF : VD_OK;
    else if (u_fail)       verdict = VD_PF;
    else if (enc_bad)      verdict = VD_PF;
    else if (st_on_ss)     verdict = VD_SAF;
    else if (fe_on_ss)     verdict = VD_IAF;
    else if (ss_mismatch)  verdict = VD_SAF;
    else if (perm_bad)     verdict = VD_PF;
    else if (sp_misal)     verdict = VD_PF;
    else                   verdict = VD_OK;
  end

  assign eff_out = k;
endmodule

// File: rtl/lpc_resp_reg.sv
module lpc_resp_reg #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  logic in_fire;

  assign in_ready = !out_valid || out_ready;
  assign in_fire  = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      if (in_fire) begin
        out_valid <= 1'b1;
        out_data  <= in_data;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  // R2
  fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_fire |=> out_valid);
endmodule

// File: rtl/leaf_perm_check.sv
module leaf_perm_check
  import lpc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  output logic       req_ready,
  input  logic       pte_v,
  input  logic       pte_r,
  input  logic       pte_w,
  input  logic       pte_x,
  input  logic       pte_u,
  input  logic [1:0] acc_kind,
  input  logic       ss_acc,
  input  logic       ss_en,
  input  logic       priv_super,
  input  logic       sum,
  input  logic       mxr,
  input  logic       bare,
  input  logic       sp_misal,
  output logic       rsp_valid,
  input  logic       rsp_ready,
  output logic [1:0] rsp_verdict,
  output logic [1:0] rsp_eff_kind
);
  localparam int PAY_W = VERD_W + KIND_W;

  pte_t              entry;
  logic [VERD_W-1:0] verdict_c;
  logic [KIND_W-1:0] eff_c;
  logic              u_fail, enc_bad, ss_mismatch, perm_bad;
  logic [PAY_W-1:0]  pay_q;
  logic              req_fire;

  assign entry    = '{v: pte_v, r: pte_r, w: pte_w, x: pte_x, u: pte_u};
  assign req_fire = req_valid && req_ready;

  lpc_rules u_rules (
    .pte        (entry),
    .kind_in    (acc_kind),
    .ss_acc     (ss_acc),
    .ss_en      (ss_en),
    .priv_super (priv_super),
    .sum        (sum),
    .mxr        (mxr),
    .bare       (bare),
    .sp_misal   (sp_misal),
    .verdict    (verdict_c),
    .eff_out    (eff_c),
    .u_fail     (u_fail),
    .enc_bad    (enc_bad),
    .ss_mismatch(ss_mismatch),
    .perm_bad   (perm_bad)
  );

  lpc_resp_reg #(.W(PAY_W)) u_resp (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (req_valid),
    .in_ready (req_ready),
    .in_data  ({verdict_c, eff_c}),
    .out_valid(rsp_valid),
    .out_ready(rsp_ready),
    .out_data (pay_q)
  );

  assign rsp_verdict  = pay_q[PAY_W-1 -: VERD_W];
  assign rsp_eff_kind = pay_q[KIND_W-1:0];

  // R3
  ss_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_fire && ss_acc |=> rsp_eff_kind == 2'b01);

  // R4
  ss_bare_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_fire && ss_acc && bare |=> rsp_verdict == 2'b10);

  // R6
  inv_pf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_fire && !bare && !u_fail && !pte_v |=> rsp_verdict == 2'b01);

  // R9
  ss_mis_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_fire && !bare && !u_fail && !enc_bad && ss_mismatch |=> rsp_verdict == 2'b10);

  // R11
  misal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_fire && !bare && !u_fail && !enc_bad && !ss_acc && !perm_bad && sp_misal
    && !(pte_w && !pte_r && !pte_x) |=> rsp_verdict == 2'b01);
endmodule

// File: tb/sim_leaf_perm_check.sv
module sim_leaf_perm_check;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic pte_v = 0, pte_r = 0, pte_w = 0, pte_x = 0, pte_u = 0;
  logic [1:0] acc_kind = 2'd0;
  logic ss_acc = 0, ss_en = 0, priv_super = 0, sum = 0, mxr = 0, bare = 0, sp_misal = 0;
  logic rsp_valid;
  logic rsp_ready = 1'b1;
  logic [1:0] rsp_verdict, rsp_eff_kind;

  int checks = 0;
  int fails = 0;
  string cur_tag = "";

  logic [3:0] exp_q[$];
  string      tag_q[$];
  logic       prev_stall = 1'b0;
  logic [3:0] prev_out = '0;

  always #4 clk = ~clk;

  leaf_perm_check u0 (.*);

  // behavioural reference: walks the rule list in order, returns verdict/kind/rule
  task automatic model(output logic [1:0] v, output logic [1:0] e, output string tag);
    int kind;
    bit wo, blocked, need_ok;
    kind = ss_acc ? 1 : (acc_kind == 2'd3 ? 0 : int'(acc_kind));
    e = 2'(kind);
    wo = (!pte_r && pte_w && !pte_x);
    if (pte_u) blocked = priv_super && (kind == 2 || !sum);
    else       blocked = !priv_super;
    case (kind)
      2: need_ok = pte_x;
      1: need_ok = pte_w;
      default: need_ok = pte_r || (mxr && pte_x);
    endcase
    if (bare) begin v = ss_acc ? 2'd2 : 2'd0; tag = "R4"; end
    else if (blocked) begin v = 2'd1; tag = "R5"; end
    else if (!pte_v || (!pte_r && pte_w && pte_x) || (wo && !ss_en)) begin v = 2'd1; tag = "R6"; end
    else if (wo && kind == 1 && !ss_acc) begin v = 2'd2; tag = "R7"; end
    else if (wo && kind == 2) begin v = 2'd3; tag = "R8"; end
    else if (ss_acc && (pte_x || (pte_r && pte_w))) begin v = 2'd2; tag = "R9"; end
    else if (!need_ok) begin v = 2'd1; tag = "R10"; end
    else if (sp_misal) begin v = 2'd1; tag = "R11"; end
    else begin v = 2'd0; tag = "R10"; end
  endtask

  always @(posedge clk) begin
    if (rst_n) begin
      if (rsp_valid && rsp_ready && exp_q.size() > 0) begin
        void'(exp_q.pop_front());
        void'(tag_q.pop_front());
      end
      if (req_valid && req_ready) begin
        logic [1:0] v, e;
        string t;
        model(v, e, t);
        exp_q.push_back({v, e});
        tag_q.push_back(cur_tag != "" ? cur_tag : t);
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_stall) begin
        checks++;
        if (!rsp_valid || {rsp_verdict, rsp_eff_kind} != prev_out) begin
          fails++;
          $display("FAIL R2 held response: got valid=%0b %h expected valid=1 %h",
                   rsp_valid, {rsp_verdict, rsp_eff_kind}, prev_out);
        end
      end
      if (rsp_valid) begin
        if (exp_q.size() == 0) begin
          checks++; fails++;
          $display("FAIL R2 unexpected response: got %h expected none", {rsp_verdict, rsp_eff_kind});
        end else begin
          checks++;
          if (rsp_verdict != exp_q[0][3:2]) begin
            fails++;
            $display("FAIL %s verdict: got %0d expected %0d", tag_q[0], rsp_verdict, exp_q[0][3:2]);
          end
          checks++;
          if (rsp_eff_kind != exp_q[0][1:0]) begin
            fails++;
            $display("FAIL R3 effective kind: got %0d expected %0d", rsp_eff_kind, exp_q[0][1:0]);
          end
        end
      end else if (exp_q.size() > 0) begin
        checks++; fails++;
        $display("FAIL R2 missing response: got valid=0 expected valid=1");
      end
      prev_stall = rsp_valid && !rsp_ready;
      prev_out = {rsp_verdict, rsp_eff_kind};
    end
  end

  task automatic drv(input logic [4:0] vrwxu, input logic [1:0] k, input logic ss,
                     input logic sse, input logic sup, input logic su, input logic mx,
                     input logic br, input logic mis, input string tag);
    @(negedge clk);
    {pte_v, pte_r, pte_w, pte_x, pte_u} = vrwxu;
    acc_kind = k; ss_acc = ss; ss_en = sse; priv_super = sup; sum = su;
    mxr = mx; bare = br; sp_misal = mis; cur_tag = tag;
    req_valid = 1'b1; rsp_ready = 1'b1;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got no end of run expected finish");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    checks++;
    if (rsp_valid !== 1'b0 || req_ready !== 1'b1) begin
      fails++;
      $display("FAIL R1 reset: got valid=%b ready=%b expected valid=0 ready=1", rsp_valid, req_ready);
    end
    // directed corners: {v,r,w,x,u}, kind, ss, sse, super, sum, mxr, bare, misal
    drv(5'b10000, 2'd1, 1, 1, 1, 0, 0, 1, 0, "R4");
    drv(5'b00000, 2'd0, 0, 0, 1, 0, 0, 1, 1, "R4");
    drv(5'b11011, 2'd2, 0, 0, 1, 1, 0, 0, 0, "R5");
    drv(5'b11001, 2'd0, 0, 0, 1, 0, 0, 0, 0, "R5");
    drv(5'b11001, 2'd0, 0, 0, 1, 1, 0, 0, 0, "R5");
    drv(5'b11000, 2'd0, 0, 0, 0, 0, 0, 0, 0, "R5");
    drv(5'b01110, 2'd0, 0, 1, 1, 0, 0, 0, 0, "R6");
    drv(5'b10110, 2'd0, 0, 1, 1, 0, 0, 0, 0, "R6");
    drv(5'b10100, 2'd0, 0, 0, 1, 0, 0, 0, 0, "R6");
    drv(5'b10100, 2'd1, 1, 0, 1, 0, 0, 0, 0, "R6");
    drv(5'b10100, 2'd1, 0, 1, 1, 0, 0, 0, 0, "R7");
    drv(5'b10100, 2'd2, 0, 1, 1, 0, 0, 0, 0, "R8");
    drv(5'b11100, 2'd0, 1, 1, 1, 0, 0, 0, 0, "R9");
    drv(5'b10010, 2'd2, 1, 1, 1, 0, 0, 0, 0, "R9");
    drv(5'b10100, 2'd2, 1, 1, 1, 0, 0, 0, 0, "R10");
    drv(5'b10010, 2'd0, 0, 0, 1, 0, 1, 0, 0, "R10");
    drv(5'b10010, 2'd3, 0, 0, 1, 0, 0, 0, 0, "R10");
    drv(5'b11000, 2'd1, 0, 0, 1, 0, 0, 0, 0, "R10");
    drv(5'b11100, 2'd1, 0, 0, 1, 0, 0, 0, 0, "R10");
    drv(5'b11000, 2'd1, 1, 1, 1, 0, 0, 0, 0, "R10");
    drv(5'b11010, 2'd2, 0, 0, 1, 0, 0, 0, 1, "R11");
    drv(5'b11100, 2'd1, 0, 0, 1, 0, 0, 0, 1, "R11");
    drv(5'b00001, 2'd1, 1, 1, 0, 0, 0, 1, 0, "R12");
    drv(5'b10101, 2'd1, 0, 1, 1, 0, 0, 0, 1, "R12");
    drv(5'b10100, 2'd1, 0, 1, 1, 0, 0, 0, 1, "R12");
    drv(5'b11110, 2'd1, 1, 1, 1, 0, 0, 0, 1, "R12");
    // random sweep with back-pressure
    for (int i = 0; i < 6000; i++) begin
      @(negedge clk);
      cur_tag = "";
      {pte_v, pte_r, pte_w, pte_x, pte_u} = 5'($urandom);
      if ($urandom_range(0, 3) != 0) pte_v = 1'b1;
      acc_kind = 2'($urandom);
      {ss_acc, ss_en, priv_super, sum, mxr} = 5'($urandom);
      bare = ($urandom_range(0, 7) == 0);
      sp_misal = ($urandom_range(0, 3) == 0);
      req_valid = ($urandom_range(0, 4) != 0);
      rsp_ready = ($urandom_range(0, 3) != 0);
    end
    @(negedge clk);
    req_valid = 1'b0;
    rsp_ready = 1'b1;
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule